// File: doc/BRIEF.md
# Microcode Sequencer with Store-Destination Decode

This block is the control core of a small microcoded 8-bit processor. A phase counter walks through the micro-steps of the current instruction. Each cycle the opcode, the phase and all four condition flags together address a control store, and the control word found there drives the datapath for that cycle. A control word can end the instruction, which sends the phase back to zero on the next clock edge. Otherwise the phase advances by one.

The low field of the control word names the register that stores the data bus value in this cycle. A decoder turns that field into one-hot load enables for ten targets. The last two targets are the low and high bytes of the stack pointer, so microcode can save and restore the stack pointer. Every flag value has its own control-store entry, so a conditional micro-step costs no extra cycles whichever flag it tests. The control store is an internal array that is filled through a simple synchronous write port. Only the first `MAPPED_OPC` opcodes have storage behind them.

Top module: `mseq_top`

## Requirements
- R1: While `rst` is high, the phase is 0, so `ctl_word` shows the entry for {opcode, phase 0, flags}.
- R2: The control store address is {opcode[7:0], phase[3:0], flags[3:0]}, with the opcode in bits 15:8, the phase in bits 7:4 and the flags in bits 3:0.
- R3: When bit 4 of the current control word (the end bit) is 0 and `rst` is low, the phase advances by one at each clock edge, wrapping from 15 to 0.
- R4: When the end bit is 1, the phase is 0 after the next clock edge.
- R5: A change on `flags` or `opcode` selects the matching entry in the same cycle, with no clock edge in between.
- R6: Destination field `ctl_word[3:0]` with value k from 1 to 10 drives exactly `ld_en[k-1]` high.
- R7: Destination code 0 (no store) and codes 11 to 15 leave every bit of `ld_en` low.
- R8: Code 9 loads the stack pointer low byte through `ld_en[8]`, and code 10 loads the high byte through `ld_en[9]`.
- R9: For an opcode at or above `MAPPED_OPC` (default 8), the block reads an all-zero control word and ignores writes.
- R10: When `wr_en` is high at a clock edge, `wr_data` is stored at `wr_addr`. From that edge on, the entry reads back the new word whenever it is addressed.

Bit 4 of every control word is the end bit, and bits 23:5 go to the datapath unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the phase |
| opcode | input | 8 | Current instruction opcode |
| flags | input | 4 | Condition flags |
| wr_en | input | 1 | Control store write strobe |
| wr_addr | input | 16 | Control store write address |
| wr_data | input | 24 | Control store write data |
| ctl_word | output | 24 | Control word for the current cycle |
| ld_en | output | 10 | One-hot register load enables, active high |

## Verification
The checker watches the phase sequencing on every cycle: the advance by one, the return to zero after an end bit and the zero phase after reset. It also checks that the decoded enables match the destination field, including the idle codes and the two stack pointer codes. The bench's scenarios are the only place that shows address composition, same-cycle flag selection, ignored writes to unmapped opcodes and the exact edge at which a write becomes visible. For these, the bench fills the store with words that encode their own address.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   // Named store destinations for the default 4-bit field
   typedef enum logic [3:0] {
      DST_NONE  = 4'd0,
      DST_ACC   = 4'd1,
      DST_IDX   = 4'd2,
      DST_TMP   = 4'd3,
      DST_PCL   = 4'd4,
      DST_PCH   = 4'd5,
      DST_ADL   = 4'd6,
      DST_ADH   = 4'd7,
      DST_OPR   = 4'd8,
      DST_SPL   = 4'd9,
      DST_SPH   = 4'd10
   } dst_code_e;

   // Destination field starts at bit 0, end bit sits directly above it
   localparam int unsigned DST_LSB = 0;
endpackage

// File: rtl/mseq_phase_ctr.sv
module mseq_phase_ctr #(
   parameter int unsigned PH_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            end_i,
   output logic [PH_W-1:0] phase_o
);
   always_ff @(posedge clk) begin
      if (rst)
         phase_o <= '0;
      else if (end_i)
         phase_o <= '0;
      else
         phase_o <= phase_o + 1'b1;
   end
endmodule

// File: rtl/mseq_ctl_store.sv
module mseq_ctl_store #(
   parameter int unsigned OPC_W      = 8,
   parameter int unsigned PH_W       = 4,
   parameter int unsigned FL_W       = 4,
   parameter int unsigned CW_W       = 24,
   parameter int unsigned MAPPED_OPC = 8
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [OPC_W+PH_W+FL_W-1:0]  wr_addr,
   input  logic [CW_W-1:0]             wr_data,
   input  logic [OPC_W+PH_W+FL_W-1:0]  rd_addr,
   output logic [CW_W-1:0]             rd_data
);
   localparam int unsigned AW    = OPC_W + PH_W + FL_W;
   localparam int unsigned LOW_W = PH_W + FL_W;
   localparam int unsigned FULL  = 1 << OPC_W;

   generate
      if (MAPPED_OPC == FULL) begin : g_full
         logic [CW_W-1:0] mem [1 << AW];
         always_ff @(posedge clk) begin
            if (wr_en)
               mem[wr_addr] <= wr_data;
         end
         assign rd_data = mem[rd_addr];
      end else begin : g_part
         localparam int unsigned MAP_W = $clog2(MAPPED_OPC);
         localparam int unsigned IDX_W = MAP_W + LOW_W;
         logic [CW_W-1:0]  mem [1 << IDX_W];
         logic             wr_hit, rd_hit;
         logic [IDX_W-1:0] wr_idx, rd_idx;

         assign wr_hit = wr_addr[AW-1:LOW_W] < OPC_W'(MAPPED_OPC);
         assign rd_hit = rd_addr[AW-1:LOW_W] < OPC_W'(MAPPED_OPC);
         assign wr_idx = {wr_addr[LOW_W+MAP_W-1:LOW_W], wr_addr[LOW_W-1:0]};
         assign rd_idx = {rd_addr[LOW_W+MAP_W-1:LOW_W], rd_addr[LOW_W-1:0]};

         always_ff @(posedge clk) begin
            if (wr_en && wr_hit)
               mem[wr_idx] <= wr_data;
         end
         assign rd_data = rd_hit ? mem[rd_idx] : '0;
      end
   endgenerate
endmodule

// File: rtl/mseq_dest_dec.sv
module mseq_dest_dec #(
   parameter int unsigned DST_W = 4,
   parameter int unsigned N_DST = 10
) (
   input  logic [DST_W-1:0] dst_i,
   output logic [N_DST-1:0] ld_en_o
);
   // Code 0 is the idle code, target g answers to code g+1
   generate
      for (genvar g = 0; g < N_DST; g++) begin : g_tgt
         assign ld_en_o[g] = (dst_i == DST_W'(g + 1));
      end
   endgenerate
endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
   parameter int unsigned OPC_W      = 8,
   parameter int unsigned PH_W       = 4,
   parameter int unsigned FL_W       = 4,
   parameter int unsigned CW_W       = 24,
   parameter int unsigned DST_W      = 4,
   parameter int unsigned N_DST      = 10,
   parameter int unsigned MAPPED_OPC = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [OPC_W-1:0]            opcode,
   input  logic [FL_W-1:0]             flags,
   input  logic                        wr_en,
   input  logic [OPC_W+PH_W+FL_W-1:0]  wr_addr,
   input  logic [CW_W-1:0]             wr_data,
   output logic [CW_W-1:0]             ctl_word,
   output logic [N_DST-1:0]            ld_en
);
   import mseq_pkg::*;

   localparam int unsigned AW      = OPC_W + PH_W + FL_W;
   localparam int unsigned END_POS = DST_LSB + DST_W;

   generate
      if (N_DST > (1 << DST_W) - 1) begin : g_bad_ndst
         $error("N_DST needs more codes than DST_W provides");
      end
      if (CW_W < END_POS + 1) begin : g_bad_cw
         $error("CW_W too narrow for destination field and end bit");
      end
      if (MAPPED_OPC < 2 || MAPPED_OPC > (1 << OPC_W)) begin : g_bad_map
         $error("MAPPED_OPC out of range");
      end
   endgenerate

   logic [PH_W-1:0]  phase_q;
   logic [AW-1:0]    rd_addr;
   logic             end_bit;
   logic [DST_W-1:0] dst;

   assign rd_addr = {opcode, phase_q, flags};
   assign end_bit = ctl_word[END_POS];
   assign dst     = ctl_word[DST_LSB +: DST_W];

   mseq_phase_ctr #(.PH_W(PH_W)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .end_i   (end_bit),
      .phase_o (phase_q)
   );

   mseq_ctl_store #(
      .OPC_W(OPC_W), .PH_W(PH_W), .FL_W(FL_W),
      .CW_W(CW_W), .MAPPED_OPC(MAPPED_OPC)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (ctl_word)
   );

   mseq_dest_dec #(.DST_W(DST_W), .N_DST(N_DST)) u_dec (
      .dst_i   (dst),
      .ld_en_o (ld_en)
   );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
   parameter int unsigned PH_W  = 4,
   parameter int unsigned CW_W  = 24,
   parameter int unsigned DST_W = 4,
   parameter int unsigned N_DST = 10
) (
   input logic            clk,
   input logic            rst,
   input logic [PH_W-1:0] phase,
   input logic [CW_W-1:0] ctl_word,
   input logic [N_DST-1:0] ld_en
);
   localparam int unsigned END_POS = mseq_pkg::DST_LSB + DST_W;

   logic [DST_W-1:0] dcode;
   logic             eob;
   assign dcode = ctl_word[mseq_pkg::DST_LSB +: DST_W];
   assign eob   = ctl_word[END_POS];

   // R1
   reset_phase_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> phase == '0);

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      !eob |=> phase == PH_W'($past(phase) + 1'b1));

   // R4
   end_return_chk: assert property (@(posedge clk) disable iff (rst)
      eob |=> phase == '0);

   // R6
   onehot_load_chk: assert property (@(posedge clk) disable iff (rst)
      (dcode >= DST_W'(1) && dcode <= DST_W'(N_DST))
         |-> ($countones(ld_en) == 1 && ld_en[dcode - 1'b1]));

   // R7
   idle_code_chk: assert property (@(posedge clk) disable iff (rst)
      (dcode == '0 || dcode > DST_W'(N_DST)) |-> ld_en == '0);

   // R8
   sp_low_chk: assert property (@(posedge clk) disable iff (rst)
      (dcode == DST_W'(mseq_pkg::DST_SPL)) |-> ld_en[N_DST-2]);

   // R8
   sp_high_chk: assert property (@(posedge clk) disable iff (rst)
      (dcode == DST_W'(mseq_pkg::DST_SPH)) |-> ld_en[N_DST-1]);
endmodule

bind mseq_top mseq_chk #(
   .PH_W(PH_W), .CW_W(CW_W), .DST_W(DST_W), .N_DST(N_DST)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .phase    (phase_q),
   .ctl_word (ctl_word),
   .ld_en    (ld_en)
);

// File: tb/test_mseq_top.sv
module test_mseq_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  opcode = '0;
   logic [3:0]  flags = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [23:0] wr_data = '0;
   logic [23:0] ctl_word;
   logic [9:0]  ld_en;

   int errs = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   mseq_top i_mseq_top (
      .clk(clk), .rst(rst), .opcode(opcode), .flags(flags),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctl_word(ctl_word), .ld_en(ld_en)
   );

   function automatic logic [23:0] mkw(input logic [7:0] op, input logic [3:0] ph,
                                       input logic [3:0] fl, input logic e,
                                       input logic [3:0] d);
      return {op, ph, fl, 3'b000, e, d};
   endfunction

   function automatic logic [9:0] exp_ld(input int c);
      return (c >= 1 && c <= 10) ? 10'(1 << (c - 1)) : 10'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic store(input logic [15:0] a, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic hold_reset();
      @(negedge clk) rst = 1'b1;
      @(posedge clk);
      #1;
   endtask

   // R1, R3: reset phase and free-running step with wrap
   task automatic t_reset_and_step();
      hold_reset();
      for (int p = 0; p < 16; p++) store({8'd3, 4'(p), 4'd0}, mkw(8'd3, 4'(p), 4'd0, 1'b0, 4'd0));
      opcode = 8'd3; flags = 4'd0;
      @(negedge clk);
      chk("R1 reset phase", ctl_word, mkw(8'd3, 4'd0, 4'd0, 1'b0, 4'd0));
      rst = 1'b0;
      for (int k = 1; k <= 17; k++) begin
         @(negedge clk);
         chk("R3 phase step", ctl_word, mkw(8'd3, 4'(k % 16), 4'd0, 1'b0, 4'd0));
      end
   endtask

   // R4: end bit returns phase to 0
   task automatic t_end();
      hold_reset();
      for (int p = 0; p < 16; p++)
         store({8'd4, 4'(p), 4'd0}, mkw(8'd4, 4'(p), 4'd0, p == 2, 4'd0));
      opcode = 8'd4;
      @(negedge clk) rst = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 at end step", ctl_word, mkw(8'd4, 4'd2, 4'd0, 1'b1, 4'd0));
      @(negedge clk);
      chk("R4 back to 0", ctl_word, mkw(8'd4, 4'd0, 4'd0, 1'b0, 4'd0));
      @(negedge clk);
      chk("R4 then 1", ctl_word, mkw(8'd4, 4'd1, 4'd0, 1'b0, 4'd0));
   endtask

   // R2, R5: flags and opcode select entries in the same cycle
   task automatic t_flags();
      hold_reset();
      for (int f = 0; f < 16; f++) store({8'd5, 4'd0, 4'(f)}, mkw(8'd5, 4'd0, 4'(f), 1'b0, 4'd0));
      opcode = 8'd5;
      for (int f = 15; f >= 0; f--) begin
         @(negedge clk);
         flags = 4'(f);
         #1 chk("R5 flag select", ctl_word, mkw(8'd5, 4'd0, 4'(f), 1'b0, 4'd0));
      end
      flags = 4'd0; opcode = 8'd3;
      #1 chk("R2 opcode field", ctl_word, mkw(8'd3, 4'd0, 4'd0, 1'b0, 4'd0));
   endtask

   // R6, R7, R8: destination decode for every code
   task automatic t_dest();
      hold_reset();
      opcode = 8'd6; flags = 4'd0;
      for (int c = 0; c < 16; c++) begin
         store({8'd6, 4'd0, 4'd0}, mkw(8'd6, 4'd0, 4'd0, 1'b0, 4'(c)));
         @(negedge clk);
         if (c == 9 || c == 10)
            chk("R8 stack pointer half", ld_en, exp_ld(c));
         else if (c == 0 || c > 10)
            chk("R7 idle code", ld_en, exp_ld(c));
         else
            chk("R6 one-hot load", ld_en, exp_ld(c));
      end
   endtask

   // R9: unmapped opcode reads zero, write ignored
   task automatic t_unmapped();
      hold_reset();
      store({8'd200, 4'd0, 4'd0}, mkw(8'd200, 4'd0, 4'd0, 1'b1, 4'd9));
      opcode = 8'd200; flags = 4'd0;
      @(negedge clk);
      chk("R9 zero word", ctl_word, 24'd0);
      chk("R9 no load", ld_en, 10'd0);
   endtask

   // R10: write visible from its edge on
   task automatic t_write();
      hold_reset();
      opcode = 8'd7; flags = 4'd2;
      store({8'd7, 4'd0, 4'd2}, 24'h123402);
      @(negedge clk);
      chk("R10 first write", ctl_word, 24'h123402);
      wr_en = 1'b1; wr_addr = {8'd7, 4'd0, 4'd2}; wr_data = 24'hABCD05;
      #1 chk("R10 old before edge", ctl_word, 24'h123402);
      @(posedge clk);
      #1 wr_en = 1'b0;
      chk("R10 new after edge", ctl_word, 24'hABCD05);
      chk("R10 decode follows", ld_en, exp_ld(5));
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errs++; checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      t_reset_and_step();
      t_end();
      t_flags();
      t_dest();
      t_unmapped();
      t_write();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule